// File: doc/BRIEF.md
# Two-Chip Nested Priority Interrupt Controller

This block gathers up to fifteen interrupt sources into one interrupt output for a processor. Inside it, two identical eight-line priority units are chained. The upper unit (master) takes lines 0 to 7. The lower unit (slave) takes lines 8 to 15. The slave's interrupt output drives the master's line 2, so master line 2 is not a request input of its own. A request placed on input 2 is sent to slave line 1, which is also fed by input 9.

Each unit catches rising edges on its request lines and keeps them pending. It masks lines one by one and chooses the lowest-numbered pending line as the winner. That winner is passed on only if it has strictly higher priority than every level already in service. When the processor acknowledges, the chosen level goes into service and the vector appears one cycle later. If the master's winner is the chaining line, the slave supplies the vector. Levels leave service through an end-of-interrupt strobe, which the processor sends to one unit at a time.

Top module: `irqc_cascade_top`

## Requirements
- R1: After reset, `int_out` and `vec_valid` are low, no level is pending or in service, every mask bit is 0 (all lines enabled) and both vector bases are 0.
- R2: A request is captured on a 0-to-1 change of its input. A line held high gives exactly one request, and it gives no new one until the line goes low and then high again.
- R3: Line 0 has the highest priority and line 7 the lowest. An acknowledge pulse (`int_ack` high for one cycle while `int_out` is high) makes `vec_valid` high for exactly the next cycle. In that cycle `vec_out` is {5-bit base, 3-bit line number} of the winner, with the base in bits 7:3.
- R4: A line whose mask bit is 1 does not raise `int_out`. Its captured request is kept, and it raises `int_out` once the mask bit is cleared.
- R5: A pending line reaches `int_out` only if its number is strictly lower than the lowest-numbered level in service. A new level can therefore preempt a level of lower priority, while a level of equal or lower priority waits.
- R6: With `eoi` high for a cycle, the selected unit (`eoi_chip` 0 is the master, 1 is the slave) drops its highest-priority in-service level. The other unit is left unchanged.
- R7: Slave lines k = 0..7 come in on `irq_req[8+k]` and reach the processor through master line 2. When line 2 wins, the acknowledge puts both master level 2 and slave level k in service, and `vec_out` is {slave base, k}.
- R8: A request on `irq_req[2]` behaves exactly like slave line 1: its vector is {slave base, 1}.
- R9: An acknowledge while `int_out` is low has no effect. `vec_valid` stays low and no level enters service.
- R10: When `cfg_wr` is high for a cycle, `cfg_chip` selects the unit. With `cfg_sel_base` = 1, bits 4:0 of `cfg_data` become the vector base. With `cfg_sel_base` = 0, `cfg_data` becomes the mask, where bit i masks line i. A mask on master line 2 blocks all slave lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 16 | Request lines; bits 15:8 go to slave lines 7:0, bit 2 goes to slave line 1 |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_chip | input | 1 | Unit for the write: 0 master, 1 slave |
| cfg_sel_base | input | 1 | 1 writes the vector base, 0 writes the mask |
| cfg_data | input | 8 | Write data |
| eoi | input | 1 | End-of-interrupt strobe |
| eoi_chip | input | 1 | Unit for the end-of-interrupt: 0 master, 1 slave |
| int_ack | input | 1 | Acknowledge pulse from the processor |
| int_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector, valid when vec_valid is high |
| vec_valid | output | 1 | High for one cycle after an accepted acknowledge |

## Verification
The bench raises several requests in the same cycle, which separates the priority order from the arrival order. It raises a request of higher priority while a level is in service, which shows preemption. It raises requests of equal and of lower priority in the same state, which shows that they are held off. It also holds lines high across their end-of-interrupt, which shows edge capture as opposed to level sensing. Slave traffic and the redirected input 2 are checked against the slave base, so that a vector taken from the wrong unit stands out. The bench also sends an end-of-interrupt to one unit alone, then changes a mask or sends an acknowledge while nothing is pending, and each of these must leave the observable outputs unchanged.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

   typedef enum logic {
      ROLE_MASTER = 1'b0,
      ROLE_SLAVE  = 1'b1
   } irqc_role_e;

   typedef struct packed {
      logic ack;
      logic eoi;
      logic mask_wr;
      logic base_wr;
   } irqc_ctl_t;

endpackage

// File: rtl/irqc_pick.sv
module irqc_pick #(
   parameter  int N  = 8,
   localparam int IW = $clog2(N)
) (
   input  logic [N-1:0]  vec_i,
   output logic          found_o,
   output logic [IW-1:0] idx_o
);

   always_comb begin
      found_o = |vec_i;
      idx_o   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec_i[i]) idx_o = IW'(i);
      end
   end

endmodule

// File: rtl/irqc_unit.sv
module irqc_unit
   import irqc_pkg::*;
#(
   parameter  int         N        = 8,
   parameter  int         VEC_W    = 8,
   parameter  int         CAS_LINE = 2,
   parameter  irqc_role_e ROLE     = ROLE_MASTER,
   localparam int         IW       = $clog2(N),
   localparam int         BASE_W   = VEC_W - IW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N-1:0]      req_i,
   input  irqc_ctl_t         ctl_i,
   input  logic [VEC_W-1:0]  cfg_i,
   output logic              int_o,
   output logic [IW-1:0]     win_o,
   output logic [BASE_W-1:0] base_o,
   output logic [N-1:0]      isr_o
);

   logic [N-1:0]      irr_eff;
   logic [N-1:0]      pend;
   logic [N-1:0]      isr_q;
   logic [N-1:0]      mask_q;
   logic [BASE_W-1:0] base_q;
   logic [N-1:0]      ack_set;
   logic [N-1:0]      eoi_clr;
   logic              p_found;
   logic [IW-1:0]     p_idx;
   logic              s_found;
   logic [IW-1:0]     s_idx;
   logic              take;

   // request capture: edge-latched lines, or a level line for the chaining input
   for (genvar g = 0; g < N; g++) begin : g_line
      if (ROLE == ROLE_MASTER && g == CAS_LINE) begin : g_level
         assign irr_eff[g] = req_i[g];
      end else begin : g_edge
         logic prev_q;
         logic irr_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               prev_q <= 1'b0;
               irr_q  <= 1'b0;
            end else begin
               prev_q <= req_i[g];
               irr_q  <= (irr_q & ~ack_set[g]) | (req_i[g] & ~prev_q);
            end
         end
         assign irr_eff[g] = irr_q;
      end
   end

   assign pend = irr_eff & ~mask_q;

   irqc_pick #(.N(N)) pend_pick_i (
      .vec_i   (pend),
      .found_o (p_found),
      .idx_o   (p_idx)
   );

   irqc_pick #(.N(N)) svc_pick_i (
      .vec_i   (isr_q),
      .found_o (s_found),
      .idx_o   (s_idx)
   );

   assign int_o   = p_found && (!s_found || (p_idx < s_idx));
   assign take    = ctl_i.ack && int_o;
   assign ack_set = take ? ({{(N-1){1'b0}}, 1'b1} << p_idx) : '0;
   assign eoi_clr = (ctl_i.eoi && s_found) ? ({{(N-1){1'b0}}, 1'b1} << s_idx) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         isr_q  <= '0;
         mask_q <= '0;
         base_q <= '0;
      end else begin
         isr_q <= (isr_q & ~eoi_clr) | ack_set;
         if (ctl_i.mask_wr) mask_q <= cfg_i[N-1:0];
         if (ctl_i.base_wr) base_q <= cfg_i[BASE_W-1:0];
      end
   end

   assign win_o  = p_idx;
   assign base_o = base_q;
   assign isr_o  = isr_q;

endmodule

// File: rtl/irqc_cascade_top.sv
module irqc_cascade_top
   import irqc_pkg::*;
#(
   parameter  int N          = 8,
   parameter  int VEC_W      = 8,
   parameter  int CAS_LINE   = 2,
   parameter  int REDIR_LINE = 1,
   localparam int IW         = $clog2(N),
   localparam int BASE_W     = VEC_W - IW,
   localparam int NREQ       = 2 * N
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NREQ-1:0]  irq_req,
   input  logic             cfg_wr,
   input  logic             cfg_chip,
   input  logic             cfg_sel_base,
   input  logic [VEC_W-1:0] cfg_data,
   input  logic             eoi,
   input  logic             eoi_chip,
   input  logic             int_ack,
   output logic             int_out,
   output logic [VEC_W-1:0] vec_out,
   output logic             vec_valid
);

   if (N < 2 || N != (1 << IW)) begin : g_bad_n
      $error("irqc_cascade_top: N must be a power of two, at least 2");
   end
   if (VEC_W < N || VEC_W <= IW) begin : g_bad_vw
      $error("irqc_cascade_top: VEC_W must hold a mask and a line number");
   end
   if (CAS_LINE >= N || REDIR_LINE >= N) begin : g_bad_line
      $error("irqc_cascade_top: chaining or redirect line out of range");
   end

   logic [N-1:0]      m_req, s_req;
   logic [N-1:0]      m_isr, s_isr;
   logic              m_int, s_int;
   logic [IW-1:0]     m_win, s_win;
   logic [BASE_W-1:0] m_base, s_base;
   irqc_ctl_t         m_ctl, s_ctl;
   logic              cas_win;
   logic              take;
   logic [VEC_W-1:0]  vec_q;
   logic              vec_v_q;

   always_comb begin
      s_req             = irq_req[NREQ-1:N];
      s_req[REDIR_LINE] = s_req[REDIR_LINE] | irq_req[CAS_LINE];
      m_req             = irq_req[N-1:0];
      m_req[CAS_LINE]   = s_int;
   end

   assign cas_win = (m_win == IW'(CAS_LINE));
   assign take    = int_ack && m_int;

   always_comb begin
      m_ctl.ack     = int_ack;
      m_ctl.eoi     = eoi && !eoi_chip;
      m_ctl.mask_wr = cfg_wr && !cfg_chip && !cfg_sel_base;
      m_ctl.base_wr = cfg_wr && !cfg_chip && cfg_sel_base;
      s_ctl.ack     = take && cas_win;
      s_ctl.eoi     = eoi && eoi_chip;
      s_ctl.mask_wr = cfg_wr && cfg_chip && !cfg_sel_base;
      s_ctl.base_wr = cfg_wr && cfg_chip && cfg_sel_base;
   end

   irqc_unit #(.N(N), .VEC_W(VEC_W), .CAS_LINE(CAS_LINE), .ROLE(ROLE_MASTER)) master_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .req_i  (m_req),
      .ctl_i  (m_ctl),
      .cfg_i  (cfg_data),
      .int_o  (m_int),
      .win_o  (m_win),
      .base_o (m_base),
      .isr_o  (m_isr)
   );

   irqc_unit #(.N(N), .VEC_W(VEC_W), .CAS_LINE(CAS_LINE), .ROLE(ROLE_SLAVE)) slave_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .req_i  (s_req),
      .ctl_i  (s_ctl),
      .cfg_i  (cfg_data),
      .int_o  (s_int),
      .win_o  (s_win),
      .base_o (s_base),
      .isr_o  (s_isr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec_q   <= '0;
         vec_v_q <= 1'b0;
      end else begin
         vec_v_q <= take;
         if (take) vec_q <= cas_win ? {s_base, s_win} : {m_base, m_win};
      end
   end

   assign int_out   = m_int;
   assign vec_out   = vec_q;
   assign vec_valid = vec_v_q;

endmodule

// File: rtl/irqc_cascade_chk.sv
module irqc_cascade_chk #(
   parameter int N        = 8,
   parameter int CAS_LINE = 2
) (
   input logic         clk,
   input logic         rst_n,
   input logic         int_ack,
   input logic         int_out,
   input logic         vec_valid,
   input logic         eoi,
   input logic         eoi_chip,
   input logic [N-1:0] m_isr,
   input logic [N-1:0] s_isr
);

   AST_VEC_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> $past(int_ack && int_out)); // R9

   AST_ACK_GIVES_VEC: assert property (@(posedge clk) disable iff (!rst_n)
      (int_ack && int_out) |=> vec_valid); // R3

   AST_SVC_ONLY_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (|(m_isr & ~$past(m_isr))) |-> $past(int_ack && int_out)); // R9

   AST_ONE_LEVEL_PER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(m_isr & ~$past(m_isr)) <= 1); // R3

   AST_EOI_DROPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && !eoi_chip && (m_isr != '0) && !int_ack)
      |=> $countones(m_isr) == $countones($past(m_isr)) - 1); // R6

   AST_EOI_OTHER_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && eoi_chip && !int_ack) |=> m_isr == $past(m_isr)); // R6

   AST_CASCADE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      (|(s_isr & ~$past(s_isr))) |-> (m_isr[CAS_LINE] && !$past(m_isr[CAS_LINE]))); // R7

endmodule

bind irqc_cascade_top irqc_cascade_chk #(.N(N), .CAS_LINE(CAS_LINE)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .int_ack   (int_ack),
   .int_out   (int_out),
   .vec_valid (vec_valid),
   .eoi       (eoi),
   .eoi_chip  (eoi_chip),
   .m_isr     (m_isr),
   .s_isr     (s_isr)
);

// File: tb/irqc_cascade_top_tb_top.sv
module irqc_cascade_top_tb_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] irq_req = '0;
   logic        cfg_wr = 1'b0, cfg_chip = 1'b0, cfg_sel_base = 1'b0;
   logic [7:0]  cfg_data = '0;
   logic        eoi = 1'b0, eoi_chip = 1'b0, int_ack = 1'b0;
   logic        int_out, vec_valid;
   logic [7:0]  vec_out;

   int    total = 0;
   int    bad = 0;
   bit    done = 0;
   string cur_tag = "R1";

   irqc_cascade_top dut_i (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .cfg_wr(cfg_wr), .cfg_chip(cfg_chip),
      .cfg_sel_base(cfg_sel_base), .cfg_data(cfg_data), .eoi(eoi), .eoi_chip(eoi_chip),
      .int_ack(int_ack), .int_out(int_out), .vec_out(vec_out), .vec_valid(vec_valid)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   // ---------------- behavioural reference model ----------------
   logic [7:0] mm_irr, mm_isr, mm_mask, mm_prev, ss_irr, ss_isr, ss_mask, ss_prev;
   logic [4:0] mm_base, ss_base;
   logic [7:0] mv;
   logic       mvv;

   function automatic int lowest(logic [7:0] v);
      for (int i = 0; i < 8; i++) if (v[i]) return i;
      return 8;
   endfunction

   function automatic logic slv_int();
      return lowest(ss_irr & ~ss_mask) < lowest(ss_isr);
   endfunction

   function automatic logic [7:0] mst_pend();
      logic [7:0] r;
      r = mm_irr;
      r[2] = slv_int();
      return r & ~mm_mask;
   endfunction

   function automatic logic mst_int();
      return lowest(mst_pend()) < lowest(mm_isr);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mm_irr = '0; mm_isr = '0; mm_mask = '0; mm_prev = '0; mm_base = '0;
         ss_irr = '0; ss_isr = '0; ss_mask = '0; ss_prev = '0; ss_base = '0;
         mv = '0; mvv = 1'b0;
      end else begin
         logic [7:0] sreq, mreq, mset, sset, mclr, sclr;
         int sp, mp;
         sreq = irq_req[15:8];
         sreq[1] = sreq[1] | irq_req[2];
         mreq = irq_req[7:0];
         sp = lowest(ss_irr & ~ss_mask);
         mp = lowest(mst_pend());
         mset = '0; sset = '0; mclr = '0; sclr = '0;
         mvv = int_ack && mst_int();
         if (mvv) begin
            mset[mp] = 1'b1;
            if (mp == 2) begin
               sset[sp] = 1'b1;
               mv = {ss_base, sp[2:0]};
            end else begin
               mv = {mm_base, mp[2:0]};
            end
         end
         if (eoi && !eoi_chip && mm_isr != 0) mclr[lowest(mm_isr)] = 1'b1;
         if (eoi && eoi_chip && ss_isr != 0) sclr[lowest(ss_isr)] = 1'b1;
         mm_isr = (mm_isr & ~mclr) | mset;
         ss_isr = (ss_isr & ~sclr) | sset;
         mm_irr = (mm_irr & ~mset) | (mreq & ~mm_prev);
         ss_irr = (ss_irr & ~sset) | (sreq & ~ss_prev);
         mm_prev = mreq;
         ss_prev = sreq;
         if (cfg_wr) begin
            if (!cfg_chip &&  cfg_sel_base) mm_base = cfg_data[4:0];
            if (!cfg_chip && !cfg_sel_base) mm_mask = cfg_data;
            if ( cfg_chip &&  cfg_sel_base) ss_base = cfg_data[4:0];
            if ( cfg_chip && !cfg_sel_base) ss_mask = cfg_data;
         end
      end
   end

   // ---------------- checking ----------------
   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(cur_tag, "model int_out", 32'(int_out), 32'(mst_int()));
         chk(cur_tag, "model vec_valid", 32'(vec_valid), 32'(mvv));
         if (mvv) chk(cur_tag, "model vec_out", 32'(vec_out), 32'(mv));
      end
   end

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic set_req(int idx, logic val);
      irq_req[idx] = val;
      tick();
   endtask

   task automatic cfg(logic chip, logic is_base, logic [7:0] data);
      cfg_wr = 1'b1; cfg_chip = chip; cfg_sel_base = is_base; cfg_data = data;
      tick();
      cfg_wr = 1'b0;
   endtask

   task automatic send_eoi(logic chip);
      eoi = 1'b1; eoi_chip = chip;
      tick();
      eoi = 1'b0;
   endtask

   task automatic ack_expect(string tag, logic [7:0] exp);
      chk(tag, "int_out before ack", 32'(int_out), 32'd1);
      int_ack = 1'b1;
      tick();
      int_ack = 1'b0;
      chk(tag, "vec_valid", 32'(vec_valid), 32'd1);
      chk(tag, "vec_out", 32'(vec_out), 32'(exp));
   endtask

   task automatic int_expect(string tag, logic exp);
      chk(tag, "int_out", 32'(int_out), 32'(exp));
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) tick();
      // R1: reset state
      int_expect("R1", 1'b0);
      chk("R1", "vec_valid in reset", 32'(vec_valid), 32'd0);
      rst_n = 1'b1;
      tick();
      int_expect("R1", 1'b0);
      chk("R1", "vec_out after reset", 32'(vec_out), 32'd0);

      // R10: bases
      cur_tag = "R10";
      cfg(1'b0, 1'b1, 8'h04);
      cfg(1'b1, 1'b1, 8'h0A);

      // R3: simultaneous requests, priority order
      cur_tag = "R3";
      irq_req[5] = 1'b1;
      set_req(3, 1'b1);
      ack_expect("R3", 8'h23);
      tick();
      chk("R3", "vec_valid one cycle only", 32'(vec_valid), 32'd0);
      int_expect("R5", 1'b0);                // line 5 below in-service 3
      cur_tag = "R6";
      send_eoi(1'b0);
      int_expect("R6", 1'b1);
      ack_expect("R3", 8'h25);
      send_eoi(1'b0);
      // R2: lines still held high, no new request
      cur_tag = "R2";
      tick(); tick();
      int_expect("R2", 1'b0);
      irq_req[3] = 1'b0; irq_req[5] = 1'b0;
      tick();
      set_req(3, 1'b1);
      int_expect("R2", 1'b1);
      ack_expect("R2", 8'h23);
      send_eoi(1'b0);
      set_req(3, 1'b0);

      // R5: nesting and preemption
      cur_tag = "R5";
      set_req(6, 1'b1);
      ack_expect("R5", 8'h26);
      set_req(1, 1'b1);
      int_expect("R5", 1'b1);
      ack_expect("R5", 8'h21);
      set_req(4, 1'b1);
      int_expect("R5", 1'b0);
      send_eoi(1'b0);                         // drops level 1, 4 beats 6
      ack_expect("R5", 8'h24);
      set_req(5, 1'b1);
      int_expect("R5", 1'b0);                 // 5 below 4
      cur_tag = "R6";
      send_eoi(1'b1);                         // slave only, master unchanged
      int_expect("R6", 1'b0);
      send_eoi(1'b0);                         // drops 4, leaves 6
      int_expect("R6", 1'b1);
      ack_expect("R6", 8'h25);
      send_eoi(1'b0);
      send_eoi(1'b0);
      irq_req[1] = 1'b0; irq_req[4] = 1'b0; irq_req[5] = 1'b0; irq_req[6] = 1'b0;
      tick();
      int_expect("R6", 1'b0);

      // R4: masking keeps the request
      cur_tag = "R4";
      cfg(1'b0, 1'b0, 8'h08);
      set_req(3, 1'b1);
      int_expect("R4", 1'b0);
      tick();
      int_expect("R4", 1'b0);
      cfg(1'b0, 1'b0, 8'h00);
      int_expect("R4", 1'b1);
      ack_expect("R4", 8'h23);
      send_eoi(1'b0);
      set_req(3, 1'b0);

      // R7: slave path and preemption over it
      cur_tag = "R7";
      set_req(12, 1'b1);
      int_expect("R7", 1'b1);
      ack_expect("R7", 8'h54);
      set_req(10, 1'b1);
      int_expect("R7", 1'b0);                 // master level 2 in service
      set_req(0, 1'b1);
      ack_expect("R7", 8'h20);
      send_eoi(1'b0);
      send_eoi(1'b1);
      int_expect("R7", 1'b0);                 // equal master level still in service
      send_eoi(1'b0);
      int_expect("R7", 1'b1);
      ack_expect("R7", 8'h52);
      send_eoi(1'b1);
      send_eoi(1'b0);
      irq_req[0] = 1'b0; irq_req[10] = 1'b0; irq_req[12] = 1'b0;
      tick();

      // R8: input 2 redirected to slave line 1
      cur_tag = "R8";
      set_req(2, 1'b1);
      ack_expect("R8", 8'h51);
      send_eoi(1'b1);
      send_eoi(1'b0);
      set_req(2, 1'b0);

      // R10: slave mask and master mask on chaining line
      cur_tag = "R10";
      cfg(1'b1, 1'b0, 8'h01);
      set_req(8, 1'b1);
      int_expect("R10", 1'b0);
      cfg(1'b1, 1'b0, 8'h00);
      ack_expect("R10", 8'h50);
      send_eoi(1'b1);
      send_eoi(1'b0);
      set_req(8, 1'b0);
      cfg(1'b0, 1'b0, 8'h04);
      set_req(15, 1'b1);
      int_expect("R10", 1'b0);
      cfg(1'b0, 1'b0, 8'h00);
      ack_expect("R10", 8'h57);
      send_eoi(1'b1);
      send_eoi(1'b0);
      set_req(15, 1'b0);

      // R9: acknowledge with nothing pending
      cur_tag = "R9";
      int_expect("R9", 1'b0);
      int_ack = 1'b1;
      tick();
      int_ack = 1'b0;
      chk("R9", "vec_valid after idle ack", 32'(vec_valid), 32'd0);
      set_req(7, 1'b1);
      ack_expect("R9", 8'h27);
      send_eoi(1'b0);
      set_req(7, 1'b0);
      tick();

      finish_run();
   end

endmodule